// File: doc/BRIEF.md
# Two-Wire Converter Slave Interface

This block is the serial front end of a byte-wide data-converter peripheral. It watches an oversampled two-wire bus (clock and data sampled on the system clock), recognises bus start and stop events, and answers to a 7-bit device address. The upper four address bits are fixed and the lower three come from strap pins. On a write transfer the first payload byte lands in a control register, and every following byte replaces the value held in a DAC code register. On a read transfer the block sends converter results back to the master and pulses a trigger toward the converter controller at the end of every acknowledge slot.

Reads are pipelined. The byte on the wire is always the result of the conversion started one acknowledge earlier, and the trigger that goes out with it starts the next one. The converter controller presents its latest finished result on `result_i` and keeps it stable between triggers. Until the first byte has been loaded after reset, the block sends a fixed mid-scale code instead.

Top module: `conv_i2c_slave`

## Requirements
- R1: A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. A start in any state, including a repeated start inside a write, restarts the address phase, so the next payload byte goes to the control register again.
- R2: The address byte is taken MSB first as binary 1001, then the pins A2 A1 A0 (`addr_pins_i[2:0]`), then the direction bit (1 = read). On a match the block holds `sda_oe_o` high (data pulled low) for the whole ninth clock.
- R3: On an address mismatch the block gives no acknowledge, drives nothing and changes no register until the next start. Stray clocks send no triggers.
- R4: The first byte after a matching write address is stored in `ctrl_o`, with bits 7 and 3 always forced to 0.
- R5: Every later byte of the same write transfer overwrites `dac_o`, which keeps its value until the next such byte.
- R6: Every byte received in a matched write transfer is acknowledged in its ninth clock.
- R7: In a read transfer, `conv_trig_o` pulses for one system clock after the clock falling edge that ends the address acknowledge and after each master acknowledge. No pulse is sent in write transfers.
- R8: Read bytes go out MSB first. `sda_oe_o` changes only after a clock falling edge or a start/stop event, and never while the clock line stays high.
- R9: The first byte read after reset is 0x80. Every later read byte is the value on `result_i` at the trigger edge that starts its transmission, which is the result of the previous conversion.
- R10: When the master does not acknowledge a read byte, the block releases the data line, sends no trigger and ignores further clocks until a start or stop.
- R11: After reset `ctrl_o` and `dac_o` are 0, `sda_oe_o` is 0 and `conv_trig_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| addr_pins_i | input | 3 | Strap pins giving the low address bits |
| result_i | input | 8 | Latest finished conversion result |
| sda_oe_o | output | 1 | 1 = pull the data line low (open drain) |
| conv_trig_o | output | 1 | One-cycle conversion start pulse |
| ctrl_o | output | 8 | Control register |
| dac_o | output | 8 | DAC code register |

## Verification
On every cycle, the embedded assertions check three things. Triggers come only right after a clock falling edge and only in read transfers. The data-line drive moves only after a falling edge or a start/stop event. The two registers change only in the cycle after their write strobe. The bench scenarios are the only proof of the values involved: address decoding against the strap pins, masking of the reserved control bits, which byte lands in which register across repeated starts, the 0x80 first read, the one-behind ordering of results, and the silence after a master not-acknowledge.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRX,
    ST_ACK,
    ST_RDX,
    ST_RDACK,
    ST_SKIP
  } link_state_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  assign scl_now = scl_pipe[STAGES-1];
  assign sda_now = sda_pipe[STAGES-1];

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs #(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  RSV_MASK = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_dac_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] dac_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d, dac_q, dac_d;

  always_comb begin
    ctrl_d = ctrl_q;
    dac_d  = dac_q;
    if (wr_ctrl_i) ctrl_d = wdata_i & ~BYTE_W'(RSV_MASK);
    if (wr_dac_i)  dac_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dac_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dac_q  <= dac_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign dac_o  = dac_q;

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr_ctrl_i));

  assert_dac_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> $past(wr_dac_i));
endmodule

// File: rtl/conv_i2c_link.sv
module conv_i2c_link
  import conv_i2c_pkg::*;
#(
  parameter int                PIN_W      = 3,
  parameter logic [6-PIN_W:0]  ADDR_FIXED = 4'b1001,
  parameter logic [7:0]        FIRST_READ = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [BYTE_W-1:0] result_i,
  output logic              sda_oe_o,
  output logic              trig_o,
  output logic              wr_ctrl_o,
  output logic              wr_dac_o,
  output logic [BYTE_W-1:0] wdata_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  link_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic rd_q, rd_d, seen_q, seen_d, fresh_q, fresh_d, mack_q, mack_d, trig_q, trig_d;
  logic wr_ctrl, wr_dac, addr_hit;
  logic [BYTE_W-1:0] load_byte;

  assign addr_hit  = (sh_q[BYTE_W-1:1] == {ADDR_FIXED, pins_i});
  assign load_byte = fresh_q ? FIRST_READ : result_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    seen_d  = seen_q;
    fresh_d = fresh_q;
    mack_d  = mack_q;
    trig_d  = 1'b0;
    wr_ctrl = 1'b0;
    wr_dac  = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      seen_d  = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WRX: begin
          if (scl_rise_i && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_WRX) begin
              state_d = ST_ACK;
              if (seen_q) wr_dac = 1'b1;
              else begin
                wr_ctrl = 1'b1;
                seen_d  = 1'b1;
              end
            end else if (addr_hit) begin
              state_d = ST_ACK;
              rd_d    = sh_q[0];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise_i) cnt_d = CNT_ONE;
          else if (scl_fall_i && cnt_q == CNT_ONE) begin
            cnt_d = '0;
            if (rd_q) begin
              state_d = ST_RDX;
              sh_d    = load_byte;
              fresh_d = 1'b0;
              trig_d  = 1'b1;
            end else begin
              state_d = ST_WRX;
            end
          end
        end
        ST_RDX: begin
          if (scl_rise_i) cnt_d = cnt_q + 1'b1;
          else if (scl_fall_i && cnt_q != '0) begin
            if (cnt_q == CNT_FULL) begin
              state_d = ST_RDACK;
              cnt_d   = '0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RDACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_i;
            cnt_d  = CNT_ONE;
          end else if (scl_fall_i && cnt_q == CNT_ONE) begin
            cnt_d = '0;
            if (mack_q) begin
              state_d = ST_RDX;
              sh_d    = load_byte;
              fresh_d = 1'b0;
              trig_d  = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      seen_q  <= 1'b0;
      fresh_q <= 1'b1;
      mack_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      seen_q  <= seen_d;
      fresh_q <= fresh_d;
      mack_q  <= mack_d;
      trig_q  <= trig_d;
    end
  end

  assign sda_oe_o  = (state_q == ST_ACK) | ((state_q == ST_RDX) & ~sh_q[BYTE_W-1]);
  assign trig_o    = trig_q;
  assign wr_ctrl_o = wr_ctrl;
  assign wr_dac_o  = wr_dac;
  assign wdata_o   = sh_q;

  assert_trig_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(scl_fall_i));

  assert_trig_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(rd_q));

  assert_oe_moves_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));
endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave #(
  parameter int               SYNC_STAGES = 2,
  parameter int               PIN_W       = 3,
  parameter logic [6-PIN_W:0] ADDR_FIXED  = 4'b1001,
  parameter logic [7:0]       FIRST_READ  = 8'h80,
  parameter logic [7:0]       RSV_MASK    = 8'h88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] addr_pins_i,
  input  logic [7:0]       result_i,
  output logic             sda_oe_o,
  output logic             conv_trig_o,
  output logic [7:0]       ctrl_o,
  output logic [7:0]       dac_o
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_ctrl, wr_dac;
  logic [7:0] wdata;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  conv_i2c_link #(.PIN_W(PIN_W), .ADDR_FIXED(ADDR_FIXED), .FIRST_READ(FIRST_READ)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_evt), .stop_i(stop_evt),
    .pins_i(addr_pins_i), .result_i(result_i), .sda_oe_o(sda_oe_o),
    .trig_o(conv_trig_o), .wr_ctrl_o(wr_ctrl), .wr_dac_o(wr_dac), .wdata_o(wdata)
  );

  conv_ctrl_regs #(.BYTE_W(8), .RSV_MASK(RSV_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_ctrl), .wr_dac_i(wr_dac),
    .wdata_i(wdata), .ctrl_o(ctrl_o), .dac_o(dac_o)
  );
endmodule

// File: tb/conv_i2c_slave_tb.sv
module conv_i2c_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 8;
  localparam int WD = 150000;
  localparam int NVEC = 5;
  // {addr byte, ctrl byte, dac byte, expected ack, expected ctrl, expected dac}
  localparam logic [47:0] WR_VEC [NVEC] = '{
    {8'h9A, 8'h45, 8'h7E, 8'h01, 8'h45, 8'h7E},
    {8'h9A, 8'hFF, 8'h01, 8'h01, 8'h77, 8'h01},
    {8'h98, 8'h12, 8'h34, 8'h00, 8'h77, 8'h01},
    {8'h1A, 8'h56, 8'h78, 8'h00, 8'h77, 8'h01},
    {8'h9A, 8'h4C, 8'hC3, 8'h01, 8'h44, 8'hC3}
  };

  logic clk, rst_n, scl_m, sda_m, scl_prev_m, oe_prev, done;
  logic [7:0] result_m, ctrl, dac;
  logic sda_oe, conv_trig;
  wire  sda_line = sda_m & ~sda_oe;
  int checks, errors, trig_cnt, oe_viol;

  conv_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(3'b101), .result_i(result_m), .sda_oe_o(sda_oe),
    .conv_trig_o(conv_trig), .ctrl_o(ctrl), .dac_o(dac)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] conv_val(input int n);
    return 8'h5A + 8'(n * 59);
  endfunction

  // converter model: finished result appears the cycle after each trigger
  always @(posedge clk) begin
    if (rst_n && conv_trig) begin
      result_m <= conv_val(trig_cnt);
      trig_cnt <= trig_cnt + 1;
    end
  end

  // R8 monitor: drive must not move while the clock line stays high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev_m && (sda_oe != oe_prev)) oe_viol <= oe_viol + 1;
    scl_prev_m <= scl_m;
    oe_prev    <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_m = 1'b1; wait_q();
      b[i] = sda_line; wait_q();
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] b;
    done = 1'b0; checks = 0; errors = 0; trig_cnt = 0; oe_viol = 0;
    result_m = 8'h00; scl_m = 1'b1; sda_m = 1'b1; scl_prev_m = 1'b1; oe_prev = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 ctrl reset", ctrl, 8'h00);
    chk("R11 dac reset", dac, 8'h00);
    chk("R11 oe reset", sda_oe, 1'b0);
    chk("R11 trig reset", conv_trig, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table: write transfers, matched and unmatched (R2 R3 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      bus_start();
      wr_byte(WR_VEC[v][47:40], a0);
      wr_byte(WR_VEC[v][39:32], a1);
      wr_byte(WR_VEC[v][31:24], a2);
      bus_stop();
      chk("R2 R3 address ack", a0, WR_VEC[v][16]);
      chk("R6 R3 ctrl byte ack", a1, WR_VEC[v][16]);
      chk("R6 R3 dac byte ack", a2, WR_VEC[v][16]);
      chk("R4 R3 ctrl value", ctrl, WR_VEC[v][15:8]);
      chk("R5 R3 dac value", dac, WR_VEC[v][7:0]);
    end
    chk("R7 no trigger in writes", trig_cnt, 0);

    // unmatched read address: silent, no trigger (R3)
    bus_start();
    wr_byte(8'h99, a0);
    chk("R3 read mismatch no ack", a0, 1'b0);
    rd_byte(1'b0, b);
    chk("R3 mismatch bus idle", b, 8'hFF);
    bus_stop();
    chk("R3 mismatch no trigger", trig_cnt, 0);

    // first read after reset and pipelined results (R9 R7 R10)
    bus_start();
    wr_byte(8'h9B, a0);
    chk("R2 read address ack", a0, 1'b1);
    chk("R7 trigger at address ack", trig_cnt, 1);
    rd_byte(1'b1, b);
    chk("R9 first read value", b, 8'h80);
    rd_byte(1'b1, b);
    chk("R9 second read value", b, conv_val(0));
    rd_byte(1'b0, b);
    chk("R9 third read value", b, conv_val(1));
    chk("R7 triggers per master ack", trig_cnt, 3);
    chk("R10 released after nack", sda_oe, 1'b0);
    rd_byte(1'b1, b);
    chk("R10 silent after nack", b, 8'hFF);
    chk("R10 no trigger after nack", trig_cnt, 3);
    bus_stop();

    bus_start();
    wr_byte(8'h9B, a0);
    rd_byte(1'b0, b);
    bus_stop();
    chk("R9 next transfer result", b, conv_val(2));
    chk("R7 trigger count", trig_cnt, 4);

    // DAC stream (R5)
    bus_start();
    wr_byte(8'h9A, a0);
    wr_byte(8'h40, a1);
    wr_byte(8'h11, a2);
    chk("R5 dac first", dac, 8'h11);
    wr_byte(8'h22, a2);
    chk("R5 dac second", dac, 8'h22);
    wr_byte(8'h33, a3);
    chk("R6 late byte ack", a3, 1'b1);
    bus_stop();
    chk("R5 dac held", dac, 8'h33);
    chk("R4 ctrl from stream", ctrl, 8'h40);

    // repeated start inside a write (R1)
    bus_start();
    wr_byte(8'h9A, a0);
    wr_byte(8'h05, a1);
    wr_byte(8'h66, a2);
    bus_start();
    wr_byte(8'h9A, a0);
    chk("R1 ack after repeated start", a0, 1'b1);
    wr_byte(8'h01, a1);
    bus_stop();
    chk("R1 ctrl after repeated start", ctrl, 8'h01);
    chk("R1 dac kept", dac, 8'h66);

    chk("R8 drive stable while clock high", oe_viol, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule